// File: doc/BRIEF.md
# Configurable GPIO Port Pin Controller

This block holds the control logic for one general-purpose I/O port of `WIDTH` pins (8 by default). Software writes three per-pin registers over a small address/write-enable/data bus: the port data latch, the output-mode register (push-pull or open-drain) and the input-mode register (digital or analog). A pin allocator supplies, per pin, an ownership flag, the value an owning peripheral wants to drive, a flag saying that the peripheral uses the pin as an input, and a forced open-drain flag. The allocator raises the forced open-drain flag for the two-wire serial data and clock pins and for a serial receive line whose controller is in its synchronous shift mode. A single global input turns off every weak pull-up.

For each pin the block produces a drive-high enable, a drive-low enable and a weak-pull-up enable for the pad. It also produces a skip flag that tells the allocator to leave analog pins alone. Pin levels enter as plain digital inputs. They pass through a two-flop synchronizer and are masked to 0 on analog pins before they reach the read-back port. Writing 1 to a latch bit while the pin is in open-drain mode leaves the pin undriven, so it can serve as a digital input.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the data latch reads all ones, the output-mode register reads all zeros and the input-mode register reads all ones. Every pin then has both drive enables low, its pull-up enabled, its skip flag low and a read-back of 0.
- R2: The register addresses are data latch = 0, output mode = 1 and input mode = 2. A write takes effect on the clock edge where `reg_we_i` is sampled high, and the new value is visible on `reg_rdata_o` after that edge. A write to address 3 changes no register, and address 3 reads as 0.
- R3: For a pin in push-pull mode (output-mode bit 1, forced open-drain flag low), drive-high equals the effective output value and drive-low equals its inverse.
- R4: For a pin in open-drain mode (output-mode bit 0), drive-high is 0 and drive-low is the inverse of the effective output value. A latch value of 1 therefore leaves the pin undriven.
- R5: A pin whose forced open-drain flag is 1 behaves as open-drain whatever its output-mode bit holds.
- R6: The effective output value of a pin is the peripheral output value when the pin is peripheral-owned, and the data latch bit otherwise. The output mode applies in both cases.
- R7: A pin that is peripheral-owned and flagged as a peripheral input has both drive enables at 0.
- R8: When the global pull-up disable input is 1, every pull-up enable is 0.
- R9: The pull-up enable of a pin is 0 whenever its drive-low enable is 1.
- R10: A pin whose input-mode bit is 0 (analog) has its skip flag at 1, its pull-up enable at 0 and its read-back at 0. Its drive enables still follow R3 to R7.
- R11: The read-back of a digital pin equals the `pin_i` level sampled two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address (0 data, 1 output mode, 2 input mode) |
| reg_wdata_i | input | WIDTH | Register write data |
| reg_rdata_o | output | WIDTH | Contents of the addressed register |
| pullup_dis_i | input | 1 | Global weak-pull-up disable |
| periph_own_i | input | WIDTH | Pin is assigned to a digital peripheral |
| periph_out_i | input | WIDTH | Value the owning peripheral drives |
| periph_in_i | input | WIDTH | Owning peripheral uses the pin as an input |
| force_od_i | input | WIDTH | Pin must act as open-drain |
| pin_i | input | WIDTH | Digital pin level from the pad |
| drv_hi_o | output | WIDTH | Drive-high enable |
| drv_lo_o | output | WIDTH | Drive-low enable |
| pull_en_o | output | WIDTH | Weak-pull-up enable |
| skip_o | output | WIDTH | Analog pin, allocator must skip it |
| pin_rd_o | output | WIDTH | Synchronized, analog-masked pin read |

## Verification
Directed vectors walk a pin through each override on its own. They cover push-pull against open-drain with a mixed latch pattern, the forced open-drain flag laid over push-pull bits, peripheral ownership with an output value that differs from the latch, and a peripheral input on owned pins. This isolates each term of the drive equations. Further directed vectors cover the global pull-up disable, a pin driving low, and the analog mode on half the pins. Together they separate the three ways a pull-up can turn off, and show that analog mode masks the read but leaves the drivers alone. A held pin step shows the two-cycle read delay, and a write to the unused address is followed by reads of every register. Random vectors with ownership and override flags biased toward a mix then cover combinations the directed set does not reach.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    ADDR_DATA  = 2'd0,
    ADDR_OMODE = 2'd1,
    ADDR_IMODE = 2'd2,
    ADDR_RSVD  = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_addr_e        addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] omode_o,
  output logic [WIDTH-1:0] imode_o,
  output logic [WIDTH-1:0] rdata_o
);

  localparam logic [WIDTH-1:0] LATCH_RST = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] OMODE_RST = {WIDTH{1'b0}};
  localparam logic [WIDTH-1:0] IMODE_RST = {WIDTH{1'b1}};

  logic wr_data, wr_omode, wr_imode;

  assign wr_data  = we_i && (addr_i == ADDR_DATA);
  assign wr_omode = we_i && (addr_i == ADDR_OMODE);
  assign wr_imode = we_i && (addr_i == ADDR_IMODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= LATCH_RST;
      omode_o <= OMODE_RST;
      imode_o <= IMODE_RST;
    end else begin
      if (wr_data)  latch_o <= wdata_i;
      if (wr_omode) omode_o <= wdata_i;
      if (wr_imode) imode_o <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA:  rdata_o = latch_o;
      ADDR_OMODE: rdata_o = omode_o;
      ADDR_IMODE: rdata_o = imode_o;
      default:    rdata_o = '0;
    endcase
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DATA) |=> (latch_o == $past(wdata_i))); // R2

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_RSVD) |=>
      ($stable(latch_o) && $stable(omode_o) && $stable(imode_o))); // R2

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
  input  logic latch_i,
  input  logic omode_i,
  input  logic imode_i,
  input  logic own_i,
  input  logic pout_i,
  input  logic pin_is_in_i,
  input  logic force_od_i,
  input  logic pull_dis_i,
  output logic drv_hi_o,
  output logic drv_lo_o,
  output logic pull_en_o,
  output logic skip_o
);

  logic eff_val, push_pull, drv_off;

  assign eff_val   = own_i ? pout_i : latch_i;
  assign push_pull = omode_i & ~force_od_i;
  // peripheral input role disables both drivers
  assign drv_off   = own_i & pin_is_in_i;

  assign drv_hi_o  = ~drv_off & push_pull & eff_val;
  assign drv_lo_o  = ~drv_off & ~eff_val;
  // analog pins and pins sinking current get no pull-up
  assign pull_en_o = ~pull_dis_i & imode_i & ~drv_lo_o;
  assign skip_o    = ~imode_i;

endmodule

// File: rtl/gpio_read_sync.sv
module gpio_read_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] imode_i,
  output logic [WIDTH-1:0] rd_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= '0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= '0;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  // analog pins read as 0
  assign rd_o = sync_q[LAST] & imode_i;

  AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sync_q[LAST] == $past(sync_q[LAST-1]))); // R11

  AST_ANALOG_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_o & ~imode_i) == '0)); // R10

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic             pullup_dis_i,
  input  logic [WIDTH-1:0] periph_own_i,
  input  logic [WIDTH-1:0] periph_out_i,
  input  logic [WIDTH-1:0] periph_in_i,
  input  logic [WIDTH-1:0] force_od_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] drv_hi_o,
  output logic [WIDTH-1:0] drv_lo_o,
  output logic [WIDTH-1:0] pull_en_o,
  output logic [WIDTH-1:0] skip_o,
  output logic [WIDTH-1:0] pin_rd_o
);

  logic [WIDTH-1:0] latch_q, omode_q, imode_q;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(reg_addr_i);

  gpio_port_regs #(.WIDTH(WIDTH)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (addr),
    .wdata_i (reg_wdata_i),
    .latch_o (latch_q),
    .omode_o (omode_q),
    .imode_o (imode_q),
    .rdata_o (reg_rdata_o)
  );

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    gpio_pin_cell i_cell (
      .latch_i     (latch_q[p]),
      .omode_i     (omode_q[p]),
      .imode_i     (imode_q[p]),
      .own_i       (periph_own_i[p]),
      .pout_i      (periph_out_i[p]),
      .pin_is_in_i (periph_in_i[p]),
      .force_od_i  (force_od_i[p]),
      .pull_dis_i  (pullup_dis_i),
      .drv_hi_o    (drv_hi_o[p]),
      .drv_lo_o    (drv_lo_o[p]),
      .pull_en_o   (pull_en_o[p]),
      .skip_o      (skip_o[p])
    );
  end

  gpio_read_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .imode_i (imode_q),
    .rd_o    (pin_rd_o)
  );

  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drv_hi_o & drv_lo_o) == '0)); // R3

  AST_FORCED_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((drv_hi_o & force_od_i) == '0)); // R5

  AST_INPUT_ROLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((drv_hi_o | drv_lo_o) & periph_own_i & periph_in_i) == '0)); // R7

  AST_PULL_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pullup_dis_i |-> (pull_en_o == '0)); // R8

  AST_PULL_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pull_en_o & drv_lo_o) == '0)); // R9

  AST_ANALOG_NO_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pull_en_o & skip_o) == '0)); // R10

endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         pd = 1'b0;
  logic [W-1:0] own = '0, pout = '0, pin_in = '0, fod = '0, pin = '0;
  logic [W-1:0] drv_hi, drv_lo, pull_en, skip, pin_rd;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_lat = '1, m_om = '0, m_im = '1, s1 = '0, s2 = '0;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.WIDTH(W)) i_gpio_port_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .pullup_dis_i (pd),
    .periph_own_i (own),
    .periph_out_i (pout),
    .periph_in_i  (pin_in),
    .force_od_i   (fod),
    .pin_i        (pin),
    .drv_hi_o     (drv_hi),
    .drv_lo_o     (drv_lo),
    .pull_en_o    (pull_en),
    .skip_o       (skip),
    .pin_rd_o     (pin_rd)
  );

  function automatic logic [W-1:0] f_eff();
    return (own & pout) | (~own & m_lat);
  endfunction

  function automatic logic [W-1:0] f_hi();
    return ~(own & pin_in) & (m_om & ~fod) & f_eff();
  endfunction

  function automatic logic [W-1:0] f_lo();
    return ~(own & pin_in) & ~f_eff();
  endfunction

  function automatic logic [W-1:0] f_pull();
    return {W{~pd}} & m_im & ~f_lo();
  endfunction

  function automatic logic [W-1:0] f_rdata();
    case (reg_addr)
      2'd0:    return m_lat;
      2'd1:    return m_om;
      2'd2:    return m_im;
      default: return '0;
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    cmp({tag, " R3/R4/R5/R6/R7"}, "drv_hi",  drv_hi,    f_hi());
    cmp({tag, " R3/R4/R6/R7"},    "drv_lo",  drv_lo,    f_lo());
    cmp({tag, " R8/R9/R10"},      "pull_en", pull_en,   f_pull());
    cmp({tag, " R10"},            "skip",    skip,      ~m_im);
    cmp({tag, " R11/R10"},        "pin_rd",  pin_rd,    s2 & m_im);
    cmp({tag, " R2"},             "rdata",   reg_rdata, f_rdata());
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic step(string tag, logic we, logic [1:0] a, logic [W-1:0] wd);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    if (we) begin
      case (a)
        2'd0: m_lat = wd;
        2'd1: m_om  = wd;
        2'd2: m_im  = wd;
        default: ;
      endcase
    end
    s2 = s1; s1 = pin;
    @(negedge clk);
    reg_we = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    cmp("R1", "drv_hi",  drv_hi,  '0);
    cmp("R1", "drv_lo",  drv_lo,  '0);
    cmp("R1", "pull_en", pull_en, '1);
    cmp("R1", "skip",    skip,    '0);
    cmp("R1", "pin_rd",  pin_rd,  '0);
    cmp("R1", "rdata",   reg_rdata, '1);
    reg_addr = 2'd1; #1; cmp("R1", "omode", reg_rdata, '0);
    reg_addr = 2'd2; #1; cmp("R1", "imode", reg_rdata, '1);
    @(negedge clk);

    step("R2", 1'b1, 2'd0, 8'hA5);
    step("R3", 1'b1, 2'd1, 8'hFF);
    step("R4", 1'b1, 2'd1, 8'h0F);
    step("R4", 1'b1, 2'd0, 8'hFF);
    step("R3", 1'b1, 2'd1, 8'hFF);
    fod = 8'h3C;
    step("R5", 1'b0, 2'd1, 8'h00);
    fod = '0; own = 8'hF0; pout = 8'h50;
    step("R6", 1'b1, 2'd0, 8'h0F);
    pin_in = 8'hCC;
    step("R7", 1'b0, 2'd0, 8'h00);
    own = '0; pin_in = '0;
    step("R9", 1'b1, 2'd0, 8'h00);
    pd = 1'b1;
    step("R8", 1'b1, 2'd0, 8'hFF);
    pd = 1'b0;
    step("R10", 1'b1, 2'd2, 8'h0F);
    step("R10", 1'b1, 2'd0, 8'h33);
    pin = 8'hFF;
    step("R11", 1'b0, 2'd2, 8'h00);
    step("R11", 1'b0, 2'd2, 8'h00);
    step("R11", 1'b1, 2'd2, 8'hFF);
    pin = 8'h96;
    step("R11", 1'b0, 2'd0, 8'h00);
    step("R11", 1'b0, 2'd0, 8'h00);
    step("R2", 1'b1, 2'd3, 8'h5A);
    step("R2", 1'b0, 2'd0, 8'h00);
    step("R2", 1'b0, 2'd1, 8'h00);
    step("R2", 1'b0, 2'd2, 8'h00);

    for (int i = 0; i < 600; i++) begin
      own    = W'($urandom) & W'($urandom);
      pout   = W'($urandom);
      pin_in = W'($urandom) & W'($urandom);
      fod    = W'($urandom) & W'($urandom) & W'($urandom);
      pd     = ($urandom % 8) == 0;
      pin    = W'($urandom);
      step("random", ($urandom % 3) != 0, 2'($urandom), W'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule